// File: doc/BRIEF.md
# Video Memory Write Queue Drain

This block holds a short circular queue of writes posted by a host data port and retires them, one per access opportunity, into three video memories: the pattern memory (VRAM), the colour table (CRAM) and the vertical scroll table (VSRAM). Each queued entry carries a 4-bit target code, a byte address, a 16-bit value and a due time. The head entry is retired only when an external access slot is offered and the current cycle count has reached the entry's due time.

The pattern memory can be wide or narrow. It is wide only when both mode inputs are set. In that case a word goes out in one slot. Otherwise the word is split into two byte writes over two successive serviced slots. The first slot writes the low byte at the partner address (address XOR 1), and the entry stays at the head. The second slot writes the high byte at the original address, and the entry is then retired. The memory ports are plain write strobes with an address and data. They are driven combinationally during the serviced cycle.

Top module: `vmem_wr_drain`

## Requirements
- R1: After reset the queue is empty, `host_ready` is 1, and an offered slot produces no memory write.
- R2: A write happens only in a cycle with `slot_active` high, a non-empty queue, and `head due <= cycle_now` (unsigned). With `due > cycle_now` the slot passes with no write and the entry is kept.
- R3: With DEPTH (default 4) entries pending, `host_ready` is 0. A `host_wr` while `host_ready` is 0 is ignored: it is never written to any memory.
- R4: Entries retire in the order they were accepted.
- R5: The low 4 bits of the code select the target: 1 = VRAM, 3 = CRAM, 5 = VSRAM. Any other code retires the entry in one slot with no write strobe. At most one write strobe is high in any cycle.
- R6: When `vram_128k` and `mode5` are both 1, a VRAM entry is written in one slot. The address is the stored address, `vram_be` = 2'b11, and the data is the full value.
- R7: When the memory is narrow, the first slot of a VRAM entry writes value[7:0] at address XOR 1, and the entry stays at the head. For a byte write the byte is copied into both halves of `vram_wdata`. `vram_be` is 2'b10 for an even address and 2'b01 for an odd address.
- R8: The next serviced slot of that entry writes value[15:8] at the original address, with the same lane rule, and retires the entry.
- R9: A CRAM write uses index address[CRAM_AW:1], where CRAM_AW = log2(CRAM_DEPTH), and carries the full value.
- R10: A VSRAM write uses index (address/2) AND 63. It is dropped (no strobe, entry retired) when that index is not below VSRAM_DEPTH (default 40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host posts an entry (taken when host_ready is 1) |
| host_code | input | 4 | Target code of the posted entry |
| host_addr | input | 16 | Byte address of the posted entry |
| host_data | input | 16 | Value of the posted entry |
| host_due | input | 16 | Earliest cycle count at which the entry may retire |
| host_ready | output | 1 | Queue has room; 0 stalls the host |
| slot_active | input | 1 | An external access slot is offered this cycle |
| cycle_now | input | 16 | Current cycle count |
| vram_128k | input | 1 | Wide pattern memory mode bit |
| mode5 | input | 1 | Extended display mode bit |
| vram_we | output | 1 | VRAM write strobe |
| vram_be | output | 2 | VRAM byte enables (bit 1 = even byte) |
| vram_addr | output | 16 | VRAM byte address |
| vram_wdata | output | 16 | VRAM write data |
| cram_we | output | 1 | CRAM write strobe |
| cram_addr | output | 6 | CRAM word index |
| cram_wdata | output | 16 | CRAM write data |
| vsram_we | output | 1 | VSRAM write strobe |
| vsram_addr | output | 6 | VSRAM word index |
| vsram_wdata | output | 16 | VSRAM write data |

## Verification
The assertions assume that the host holds `host_wr` only in whole cycles and never changes the mode inputs while a narrow VRAM entry is half written. The stimulus changes modes only when the queue is empty. The queue-depth model in the checker assumes that only handshakes with `host_ready` high add entries. The bench drives writes during full-queue stalls to exercise the ignore path. It sweeps every low address pattern in both memory widths, every wrap position of the ring, every target code and both sides of the VSRAM limit. Each expected strobe, lane and index is computed from the address arithmetic.

// File: rtl/vfd_pkg.sv
// Shared widths, target codes and queue entry layout for the write drain.
// Assumes byte addressing and 16-bit memory words.
package vfd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int TS_W   = 16;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] TGT_VRAM  = 4'd1;
    localparam logic [CODE_W-1:0] TGT_CRAM  = 4'd3;
    localparam logic [CODE_W-1:0] TGT_VSRAM = 4'd5;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   due;
    } wq_entry_t;
endpackage

// File: rtl/wfq_ring.sv
// Circular queue of pending writes, with an extra wrap bit on the pointers for full/empty.
// Assumes DEPTH is a power of two and that push is asserted only while not full.
module wfq_ring
    import vfd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wq_entry_t push_ent,
    input  logic      pop,
    output wq_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    wq_entry_t       slots [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;

    // Pointer update: advance write on push, read on pop, both modulo 2*DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Entry storage: capture the posted entry at the write index.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr[IW-1:0]] <= push_ent;
    end

    // Status and head view: same index and differing wrap bit means full.
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[IW-1:0] == rd_ptr[IW-1:0]) && (wr_ptr[IW] != rd_ptr[IW]);
        head  = slots[rd_ptr[IW-1:0]];
    end
endmodule

// File: rtl/wfq_drain.sv
// Retires the head entry into one of three memory ports, splitting narrow VRAM words into two bytes.
// Assumes the head is valid whenever empty is 0; only the head can be half written.
module wfq_drain
    import vfd_pkg::*;
#(
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wq_entry_t         head,
    input  logic              empty,
    input  logic              slot_active,
    input  logic [TS_W-1:0]   cycle_now,
    input  logic              wide_mode,
    output logic              pop,
    output logic              half_done,
    output logic              vram_we,
    output logic [1:0]        vram_be,
    output logic [ADDR_W-1:0] vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    output logic              cram_we,
    output logic [5:0]        cram_addr,
    output logic [DATA_W-1:0] cram_wdata,
    output logic              vsram_we,
    output logic [5:0]        vsram_addr,
    output logic [DATA_W-1:0] vsram_wdata
);
    localparam int CRAM_AW = $clog2(CRAM_DEPTH);

    logic              service;
    logic              split_first;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        byte_val;

    // Service decision: slot offered, entry present and due.
    always_comb service = slot_active && !empty && (head.due <= cycle_now);

    // Target decode and byte serialisation for the head entry.
    always_comb begin
        pop         = 1'b0;
        split_first = 1'b0;
        vram_we     = 1'b0;
        vram_be     = 2'b00;
        vram_addr   = head.addr;
        vram_wdata  = head.data;
        cram_we     = 1'b0;
        cram_addr   = 6'(head.addr[CRAM_AW:1]);
        cram_wdata  = head.data;
        vsram_we    = 1'b0;
        vsram_addr  = head.addr[6:1];
        vsram_wdata = head.data;
        byte_addr   = half_done ? head.addr : (head.addr ^ ADDR_W'(1));
        byte_val    = half_done ? head.data[15:8] : head.data[7:0];
        if (service) begin
            case (head.code)
                TGT_VRAM: begin
                    vram_we = 1'b1;
                    if (wide_mode) begin
                        vram_be = 2'b11;
                        pop     = 1'b1;
                    end else begin
                        vram_addr   = byte_addr;
                        vram_wdata  = {byte_val, byte_val};
                        vram_be     = byte_addr[0] ? 2'b01 : 2'b10;
                        split_first = !half_done;
                        pop         = half_done;
                    end
                end
                TGT_CRAM: begin
                    cram_we = 1'b1;
                    pop     = 1'b1;
                end
                TGT_VSRAM: begin
                    vsram_we = (32'(head.addr[6:1]) < VSRAM_DEPTH);
                    pop      = 1'b1;
                end
                default: pop = 1'b1;
            endcase
        end
    end

    // Half-written marker: set after the first byte, cleared when the entry retires.
    always_ff @(posedge clk) begin
        if (!rst_n)           half_done <= 1'b0;
        else if (split_first) half_done <= 1'b1;
        else if (pop)         half_done <= 1'b0;
    end
endmodule

// File: rtl/vmem_wr_drain.sv
// Top: host-posted write queue drained into VRAM, CRAM and VSRAM ports.
// Assumes the host holds host_wr until it sees host_ready high at a clock edge.
module vmem_wr_drain
    import vfd_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CODE_W-1:0] host_code,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [TS_W-1:0]   host_due,
    output logic              host_ready,
    input  logic              slot_active,
    input  logic [TS_W-1:0]   cycle_now,
    input  logic              vram_128k,
    input  logic              mode5,
    output logic              vram_we,
    output logic [1:0]        vram_be,
    output logic [ADDR_W-1:0] vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    output logic              cram_we,
    output logic [5:0]        cram_addr,
    output logic [DATA_W-1:0] cram_wdata,
    output logic              vsram_we,
    output logic [5:0]        vsram_addr,
    output logic [DATA_W-1:0] vsram_wdata
);
    wq_entry_t new_ent, head_ent;
    logic      q_full, q_empty, q_push, q_pop, q_half;

    // Host side: pack the posted fields and accept only when there is room.
    always_comb begin
        new_ent    = '{code: host_code, addr: host_addr, data: host_data, due: host_due};
        host_ready = !q_full;
        q_push     = host_wr && !q_full;
    end

    wfq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_ent(new_ent),
        .pop(q_pop), .head(head_ent), .full(q_full), .empty(q_empty)
    );

    wfq_drain #(.CRAM_DEPTH(CRAM_DEPTH), .VSRAM_DEPTH(VSRAM_DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .head(head_ent), .empty(q_empty),
        .slot_active(slot_active), .cycle_now(cycle_now),
        .wide_mode(vram_128k && mode5), .pop(q_pop), .half_done(q_half),
        .vram_we(vram_we), .vram_be(vram_be), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
        .vsram_we(vsram_we), .vsram_addr(vsram_addr), .vsram_wdata(vsram_wdata)
    );
endmodule

// File: rtl/wfq_checker.sv
// Property checker for vmem_wr_drain; keeps its own occupancy count from the handshakes.
// Assumes the mode inputs stay fixed while an entry is half written.
module wfq_checker #(
    parameter int DEPTH       = 4,
    parameter int VSRAM_DEPTH = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_ready,
    input logic       slot_active,
    input logic       q_pop,
    input logic       q_empty,
    input logic       q_half,
    input logic       vram_we,
    input logic [1:0] vram_be,
    input logic       cram_we,
    input logic       vsram_we,
    input logic [5:0] vsram_addr
);
    int occ;

    // Occupancy model: +1 per accepted post, -1 per retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= 0;
        else        occ <= occ + ((host_wr && host_ready) ? 1 : 0) - (q_pop ? 1 : 0);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH);
    p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready == (occ != DEPTH));
    p_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty == (occ == 0));
    p_slot_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we || cram_we || vsram_we) |-> slot_active);
    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vram_we, cram_we, vsram_we}));
    p_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we && vram_be != 2'b11 && !q_half) |=> q_half);
    p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we && vram_be != 2'b11 && q_half) |=> !q_half);
    p_vsram_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vsram_we |-> (32'(vsram_addr) < VSRAM_DEPTH));
endmodule

bind vmem_wr_drain wfq_checker #(.DEPTH(DEPTH), .VSRAM_DEPTH(VSRAM_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ready(host_ready),
    .slot_active(slot_active), .q_pop(q_pop), .q_empty(q_empty), .q_half(q_half),
    .vram_we(vram_we), .vram_be(vram_be), .cram_we(cram_we),
    .vsram_we(vsram_we), .vsram_addr(vsram_addr)
);

// File: tb/sim_vmem_wr_drain.sv
module sim_vmem_wr_drain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_code = '0;
    logic [15:0] host_addr = '0, host_data = '0, host_due = '0;
    logic        host_ready;
    logic        slot_active = 1'b0;
    logic [15:0] cycle_now = '0;
    logic        vram_128k = 1'b0, mode5 = 1'b0;
    logic        vram_we, cram_we, vsram_we;
    logic [1:0]  vram_be;
    logic [15:0] vram_addr, vram_wdata, cram_wdata, vsram_wdata;
    logic [5:0]  cram_addr, vsram_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // captured outputs of the last offered slot
    logic        c_vwe, c_cwe, c_swe;
    logic [1:0]  c_vbe;
    logic [15:0] c_vaddr, c_vdat, c_cdat, c_sdat;
    logic [5:0]  c_caddr, c_saddr;

    always #2.5 clk = ~clk;

    vmem_wr_drain u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic post(logic [3:0] code, logic [15:0] addr, logic [15:0] data, logic [15:0] due);
        @(negedge clk);
        host_wr = 1'b1; host_code = code; host_addr = addr; host_data = data; host_due = due;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic slot();
        @(negedge clk);
        slot_active = 1'b1;
        #1;
        c_vwe = vram_we; c_vbe = vram_be; c_vaddr = vram_addr; c_vdat = vram_wdata;
        c_cwe = cram_we; c_caddr = cram_addr; c_cdat = cram_wdata;
        c_swe = vsram_we; c_saddr = vsram_addr; c_sdat = vsram_wdata;
        @(negedge clk);
        slot_active = 1'b0;
    endtask

    function automatic logic [1:0] lane(logic [15:0] a);
        return a[0] ? 2'b01 : 2'b10;
    endfunction

    // Expect one VRAM write (strobe, lanes, address, data) in the last slot.
    task automatic expect_vram(string req, logic [1:0] be, logic [15:0] a, logic [15:0] d);
        check(req, {c_vwe, c_cwe, c_swe, 29'(c_vbe)}, {3'b100, 29'(be)});
        check(req, {c_vaddr, c_vdat}, {a, d});
    endtask

    task automatic expect_none(string req);
        check(req, {29'd0, c_vwe, c_cwe, c_swe}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1 check("R1 ready", 32'(host_ready), 32'd1);
        slot();
        expect_none("R1 empty slot");

        // R7/R8: narrow split of one word
        post(4'd1, 16'h1234, 16'hABCD, 16'd0);
        slot(); expect_vram("R7 first byte", 2'b01, 16'h1235, 16'hCDCD);
        slot(); expect_vram("R8 second byte", 2'b10, 16'h1234, 16'hABAB);
        slot(); expect_none("R8 retired");

        // R6: only one mode bit set stays narrow; both set is wide
        mode5 = 1'b1;
        post(4'd1, 16'h0100, 16'h5AC3, 16'd0);
        slot(); expect_vram("R6 mode5 only", 2'b01, 16'h0101, 16'hC3C3);
        slot(); expect_vram("R6 mode5 only hi", 2'b10, 16'h0100, 16'h5A5A);
        vram_128k = 1'b1;
        post(4'd1, 16'h0100, 16'h5AC3, 16'd0);
        slot(); expect_vram("R6 wide", 2'b11, 16'h0100, 16'h5AC3);
        slot(); expect_none("R6 wide retired");
        vram_128k = 1'b0; mode5 = 1'b0;

        // R7/R8/R6: sweep low address patterns in both widths
        for (int w = 0; w < 2; w++) begin
            vram_128k = w[0]; mode5 = w[0];
            for (int i = 0; i < 8; i++) begin
                logic [15:0] a, d;
                a = 16'h0200 + 16'(i);
                d = {8'(i * 17 + 1), 8'(i * 3 + 64)};
                post(4'd1, a, d, 16'd0);
                if (w == 1) begin
                    slot(); expect_vram("R6 sweep", 2'b11, a, d);
                end else begin
                    slot(); expect_vram("R7 sweep", lane(a ^ 16'd1), a ^ 16'd1, {d[7:0], d[7:0]});
                    slot(); expect_vram("R8 sweep", lane(a), a, {d[15:8], d[15:8]});
                end
            end
        end
        vram_128k = 1'b0; mode5 = 1'b0;

        // R9: CRAM index
        post(4'd3, 16'h0026, 16'h0EEE, 16'd0);
        slot();
        check("R9 cram", {29'd0, c_vwe, c_cwe, c_swe}, 32'd2);
        check("R9 cram idx", {10'd0, c_caddr, c_cdat}, {10'd0, 6'h13, 16'h0EEE});

        // R10: VSRAM index and limit
        for (int k = 0; k < 4; k++) begin
            logic [15:0] a;
            logic [5:0]  idx;
            a = (k == 0) ? 16'h004C : (k == 1) ? 16'h0052 : (k == 2) ? 16'h00D0 : 16'h0080;
            idx = 6'((a >> 1) & 16'd63);
            post(4'd5, a, 16'h1357 + 16'(k), 16'd0);
            slot();
            check("R10 vsram we", {31'd0, c_swe}, {31'd0, (idx < 6'd40)});
            if (idx < 6'd40) check("R10 vsram idx", {10'd0, c_saddr, c_sdat}, {10'd0, idx, 16'h1357 + 16'(k)});
        end

        // R2: due time gates service
        cycle_now = 16'd9;
        post(4'd3, 16'h0002, 16'h0111, 16'd10);
        slot(); expect_none("R2 not due");
        cycle_now = 16'd10;
        slot();
        check("R2 due", {31'd0, c_cwe}, 32'd1);
        check("R2 due data", {16'd0, c_cdat}, {16'd0, 16'h0111});
        cycle_now = 16'd0;

        // R5: unknown codes retire silently; next entry follows (R4 order)
        post(4'd7, 16'h0010, 16'hFFFF, 16'd0);
        post(4'd3, 16'h0004, 16'h0222, 16'd0);
        slot(); expect_none("R5 unknown code");
        slot();
        check("R5 next entry", {29'd0, c_vwe, c_cwe, c_swe}, 32'd2);
        check("R4 after skip", {10'd0, c_caddr, c_cdat}, {10'd0, 6'd2, 16'h0222});

        // R3/R4: fill at every wrap offset, post while full, drain in order
        for (int off = 0; off < 4; off++) begin
            post(4'd3, 16'h0000, 16'h0000, 16'd0);
            slot();
            for (int j = 0; j < 4; j++) post(4'd3, 16'(2 * j), 16'h0A00 + 16'(16 * off + j), 16'd0);
            #1 check("R3 full", 32'(host_ready), 32'd0);
            post(4'd5, 16'h0006, 16'hDEAD, 16'd0);
            for (int j = 0; j < 4; j++) begin
                slot();
                check("R4 order", {10'd0, c_caddr, c_cdat}, {10'd0, 6'(j), 16'h0A00 + 16'(16 * off + j)});
            end
            slot(); expect_none("R3 stalled post ignored");
            #1 check("R3 ready again", 32'(host_ready), 32'd1);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule